// File: doc/BRIEF.md
# Host Event SMI/SCI/Wake Signal Generator

This block turns a vector of pending host events into the three notification lines a host chipset watches. Each event bit is qualified by three separate type masks. The SMI-masked set drives an active-low SMI# pulse, and the SCI-masked set drives an active-low SCI# pulse. The wake-masked set, with the power-button bit always removed, drives an active-low, level-sensitive WAKE# line. The block also keeps the SMI and SCI status bits that a host mailbox exposes.

Firmware presents the current event vector and masks and strobes `update_i` whenever they change. A mailbox write on the ACPI channel is signalled on `acpi_wr_i`. `tick_us_i` is a one-cycle strobe that fires once per microsecond. Both pulse lines share one sequencer, so there is never more than one pulse on the wires at a time. A request that arrives while a pulse is running is held as a single pending pulse per line. Nothing happens until `init_done_i` is high.

Top module: `host_event_notifier`

## Requirements
- R1: An idle pulse line is high. After a pulse is dispatched, its line stays high until PHASE_US tick strobes have been counted. It is then low for exactly PHASE_US tick intervals and returns high.
- R2: On an accepted update, `smi_status_o` takes the value of OR(events & smi_mask). An SMI pulse is requested only if `smi_status_o` was 0 before that update and the SMI-masked events are now nonzero. Later updates with the events still present request no further pulse.
- R3: An accepted update with the SMI-masked events at zero clears `smi_status_o`. The next nonzero update then requests a fresh SMI pulse.
- R4: Every accepted update with nonzero SCI-masked events requests an SCI pulse. `sci_status_o` takes the value of OR(events & sci_mask) at each accepted update.
- R5: After an accepted update, `wake_no` is low when (events & wake_mask), with bit PWR_BTN_IDX cleared, is nonzero, and high otherwise.
- R6: Event bit PWR_BTN_IDX alone never drives `wake_no` low, whatever the wake mask holds.
- R7: While `init_done_i` is low, updates and mailbox writes have no effect. Status bits stay 0, no pulse is produced and `wake_no` stays high.
- R8: A mailbox write strobe (`acpi_wr_i`) with `init_done_i` high requests an SCI pulse even when no event is pending.
- R9: Requests for a line whose pulse is already running or pending collapse into one pending pulse per line, and that pulse is not lost.
- R10: When SMI and SCI pulses are pending together, the SMI pulse goes first. `smi_no` and `sci_no` are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_done_i | input | 1 | Enables all updates and requests |
| tick_us_i | input | 1 | One-cycle strobe per microsecond |
| update_i | input | 1 | Re-evaluate the events and masks this cycle |
| acpi_wr_i | input | 1 | Mailbox write on the ACPI channel; requests an SCI pulse |
| events_i | input | N_EVT | Pending host event vector |
| smi_mask_i | input | N_EVT | Events that raise SMI |
| sci_mask_i | input | N_EVT | Events that raise SCI |
| wake_mask_i | input | N_EVT | Events that drive wake |
| smi_no | output | 1 | SMI# pulse, active low |
| sci_no | output | 1 | SCI# pulse, active low |
| wake_no | output | 1 | WAKE# level, active low |
| smi_status_o | output | 1 | SMI status bit for the mailbox |
| sci_status_o | output | 1 | SCI status bit for the mailbox |

## Verification
SMI and SCI requests can arrive in the same update, and a new request can arrive in the same cycle that the sequencer dispatches or finishes a pulse. The bench sets the SMI and SCI mask bits together in a single update. It then logs which line falls first and confirms that each line produces exactly one pulse of the correct width. It also fires three SCI updates in a burst while the first SCI pulse is still running, and judges the result by the total pulse count: two pulses, with neither lost nor duplicated.

// File: rtl/hev_pkg.sv
package hev_pkg;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_LEAD, SEQ_LOW} seq_st_e;
  typedef enum logic {SRC_SMI, SRC_SCI} src_e;
endpackage

// File: rtl/hev_status.sv
module hev_status #(
  parameter int N_EVT       = 32,
  parameter int PWR_BTN_IDX = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_done_i,
  input  logic             update_i,
  input  logic             acpi_wr_i,
  input  logic [N_EVT-1:0] events_i,
  input  logic [N_EVT-1:0] smi_mask_i,
  input  logic [N_EVT-1:0] sci_mask_i,
  input  logic [N_EVT-1:0] wake_mask_i,
  output logic             smi_stat_o,
  output logic             sci_stat_o,
  output logic             wake_lvl_o,
  output logic             smi_req_o,
  output logic             sci_req_o
);
  localparam logic [N_EVT-1:0] WakeKeep = ~(N_EVT'(1) << PWR_BTN_IDX);

  logic upd, smi_any, sci_any, wake_any;
  logic smi_stat_q, sci_stat_q, wake_q;

  assign upd      = update_i & init_done_i;
  assign smi_any  = |(events_i & smi_mask_i);
  assign sci_any  = |(events_i & sci_mask_i);
  assign wake_any = |(events_i & wake_mask_i & WakeKeep);

  // SMI only on first event; SCI on every update and every mailbox write
  assign smi_req_o = upd & smi_any & ~smi_stat_q;
  assign sci_req_o = (upd & sci_any) | (acpi_wr_i & init_done_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smi_stat_q <= 1'b0;
      sci_stat_q <= 1'b0;
      wake_q     <= 1'b0;
    end else if (upd) begin
      smi_stat_q <= smi_any;
      sci_stat_q <= sci_any;
      wake_q     <= wake_any;
    end
  end

  assign smi_stat_o = smi_stat_q;
  assign sci_stat_o = sci_stat_q;
  assign wake_lvl_o = wake_q;
endmodule

// File: rtl/hev_pulse_seq.sv
module hev_pulse_seq
  import hev_pkg::*;
#(
  parameter int PHASE_US = 65
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_us_i,
  input  logic smi_req_i,
  input  logic sci_req_i,
  output logic smi_no,
  output logic sci_no
);
  localparam int CNT_W = (PHASE_US > 1) ? $clog2(PHASE_US) : 1;
  localparam logic [CNT_W-1:0] CntLast = CNT_W'(PHASE_US - 1);

  seq_st_e        st_q, st_d;
  src_e           sel_q, sel_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic           smi_pend_q, sci_pend_q;
  logic           take_smi, take_sci, phase_end;

  assign take_smi  = (st_q == SEQ_IDLE) & smi_pend_q;
  assign take_sci  = (st_q == SEQ_IDLE) & ~smi_pend_q & sci_pend_q;
  assign phase_end = tick_us_i & (cnt_q == CntLast);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smi_pend_q <= 1'b0;
      sci_pend_q <= 1'b0;
    end else begin
      // a new request wins over the dispatch clear
      smi_pend_q <= smi_req_i | (smi_pend_q & ~take_smi);
      sci_pend_q <= sci_req_i | (sci_pend_q & ~take_sci);
    end
  end

  always_comb begin
    st_d  = st_q;
    sel_d = sel_q;
    cnt_d = cnt_q;
    unique case (st_q)
      SEQ_IDLE: begin
        if (take_smi || take_sci) begin
          st_d  = SEQ_LEAD;
          sel_d = take_smi ? SRC_SMI : SRC_SCI;
          cnt_d = '0;
        end
      end
      SEQ_LEAD, SEQ_LOW: begin
        if (phase_end) begin
          st_d  = (st_q == SEQ_LEAD) ? SEQ_LOW : SEQ_IDLE;
          cnt_d = '0;
        end else if (tick_us_i) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SEQ_IDLE;
      sel_q <= SRC_SMI;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      sel_q <= sel_d;
      cnt_q <= cnt_d;
    end
  end

  assign smi_no = !((st_q == SEQ_LOW) && (sel_q == SRC_SMI));
  assign sci_no = !((st_q == SEQ_LOW) && (sel_q == SRC_SCI));
endmodule

// File: rtl/host_event_notifier.sv
module host_event_notifier #(
  parameter int N_EVT       = 32,
  parameter int PWR_BTN_IDX = 1,
  parameter int PHASE_US    = 65
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_done_i,
  input  logic             tick_us_i,
  input  logic             update_i,
  input  logic             acpi_wr_i,
  input  logic [N_EVT-1:0] events_i,
  input  logic [N_EVT-1:0] smi_mask_i,
  input  logic [N_EVT-1:0] sci_mask_i,
  input  logic [N_EVT-1:0] wake_mask_i,
  output logic             smi_no,
  output logic             sci_no,
  output logic             wake_no,
  output logic             smi_status_o,
  output logic             sci_status_o
);
  logic smi_req, sci_req, wake_lvl;

  hev_status #(
    .N_EVT      (N_EVT),
    .PWR_BTN_IDX(PWR_BTN_IDX)
  ) i_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_done_i(init_done_i),
    .update_i   (update_i),
    .acpi_wr_i  (acpi_wr_i),
    .events_i   (events_i),
    .smi_mask_i (smi_mask_i),
    .sci_mask_i (sci_mask_i),
    .wake_mask_i(wake_mask_i),
    .smi_stat_o (smi_status_o),
    .sci_stat_o (sci_status_o),
    .wake_lvl_o (wake_lvl),
    .smi_req_o  (smi_req),
    .sci_req_o  (sci_req)
  );

  hev_pulse_seq #(
    .PHASE_US(PHASE_US)
  ) i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_us_i(tick_us_i),
    .smi_req_i(smi_req),
    .sci_req_i(sci_req),
    .smi_no   (smi_no),
    .sci_no   (sci_no)
  );

  assign wake_no = ~wake_lvl;
endmodule

// File: rtl/hev_chk.sv
module hev_chk #(
  parameter int N_EVT       = 32,
  parameter int PWR_BTN_IDX = 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             init_done_i,
  input logic             tick_us_i,
  input logic             update_i,
  input logic [N_EVT-1:0] events_i,
  input logic [N_EVT-1:0] smi_mask_i,
  input logic [N_EVT-1:0] sci_mask_i,
  input logic [N_EVT-1:0] wake_mask_i,
  input logic             smi_no,
  input logic             sci_no,
  input logic             wake_no,
  input logic             smi_status_o,
  input logic             sci_status_o
);
  localparam logic [N_EVT-1:0] PwrBit = N_EVT'(1) << PWR_BTN_IDX;

  AST_PINS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_no || sci_no); // R10

  AST_SMI_LOW_ENDS_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smi_no && !tick_us_i |=> !smi_no); // R1

  AST_SCI_LOW_ENDS_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sci_no && !tick_us_i |=> !sci_no); // R1

  AST_SMI_STATUS_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i && init_done_i |=> smi_status_o == $past(|(events_i & smi_mask_i))); // R3

  AST_SCI_STATUS_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i && init_done_i |=> sci_status_o == $past(|(events_i & sci_mask_i))); // R4

  AST_WAKE_PWR_EXCLUDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i && init_done_i && ((events_i & wake_mask_i & ~PwrBit) == '0) |=> wake_no); // R6

  AST_NO_STATUS_PREINIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_done_i && !smi_status_o |=> !smi_status_o); // R7
endmodule

bind host_event_notifier hev_chk #(
  .N_EVT      (N_EVT),
  .PWR_BTN_IDX(PWR_BTN_IDX)
) i_hev_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .init_done_i (init_done_i),
  .tick_us_i   (tick_us_i),
  .update_i    (update_i),
  .events_i    (events_i),
  .smi_mask_i  (smi_mask_i),
  .sci_mask_i  (sci_mask_i),
  .wake_mask_i (wake_mask_i),
  .smi_no      (smi_no),
  .sci_no      (sci_no),
  .wake_no     (wake_no),
  .smi_status_o(smi_status_o),
  .sci_status_o(sci_status_o)
);

// File: tb/test_host_event_notifier.sv
`timescale 1ns/1ps
module test_host_event_notifier;
  localparam int NE    = 8;
  localparam int PWR   = 2;
  localparam int PH    = 3;
  localparam int TDIV  = 4;
  localparam int LOW_W = PH * TDIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_done = 1'b0, tick = 1'b0, upd = 1'b0, acpi_wr = 1'b0;
  logic [NE-1:0] ev = '0;
  logic [NE-1:0] smi_m = 8'h01, sci_m = 8'h02, wake_m = 8'h0C;
  logic smi_n, sci_n, wake_n, smi_st, sci_st;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  int smi_cnt = 0, sci_cnt = 0, smi_w = 0, sci_w = 0;
  int smi_run = 0, sci_run = 0;
  int order_log [8];
  int log_idx = 0;
  logic smi_prev = 1'b1, sci_prev = 1'b1;

  always #2.5 clk = ~clk;

  host_event_notifier #(.N_EVT(NE), .PWR_BTN_IDX(PWR), .PHASE_US(PH)) i_host_event_notifier (
    .clk_i(clk), .rst_ni(rst_n), .init_done_i(init_done), .tick_us_i(tick),
    .update_i(upd), .acpi_wr_i(acpi_wr), .events_i(ev), .smi_mask_i(smi_m),
    .sci_mask_i(sci_m), .wake_mask_i(wake_m), .smi_no(smi_n), .sci_no(sci_n),
    .wake_no(wake_n), .smi_status_o(smi_st), .sci_status_o(sci_st));

  // tick generator
  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      c = (c + 1) % TDIV;
      tick = (c == 0);
    end
  end

  // pulse monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!smi_n) smi_run++;
      if (!sci_n) sci_run++;
      if (smi_prev && !smi_n && log_idx < 8) begin order_log[log_idx] = 1; log_idx++; end
      if (sci_prev && !sci_n && log_idx < 8) begin order_log[log_idx] = 2; log_idx++; end
      if (!smi_prev && smi_n) begin smi_cnt++; smi_w = smi_run; smi_run = 0; end
      if (!sci_prev && sci_n) begin sci_cnt++; sci_w = sci_run; sci_run = 0; end
      smi_prev = smi_n;
      sci_prev = sci_n;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    smi_cnt = 0; sci_cnt = 0; smi_w = 0; sci_w = 0; log_idx = 0;
  endtask

  task automatic do_update(input logic [NE-1:0] v);
    @(negedge clk); ev = v; upd = 1'b1;
    @(negedge clk); upd = 1'b0;
  endtask

  task automatic do_acpi();
    @(negedge clk); acpi_wr = 1'b1;
    @(negedge clk); acpi_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(smi_n == 1'b1, "R1 smi idle", smi_n, 1);
    chk(sci_n == 1'b1, "R1 sci idle", sci_n, 1);
    chk(wake_n == 1'b1, "R5 wake reset", wake_n, 1);
    chk(smi_st == 1'b0 && sci_st == 1'b0, "R2 status reset", {smi_st, sci_st}, 0);
  endtask

  task automatic t_preinit();
    clear_mon();
    do_update(8'hFF);
    do_acpi();
    idle(60);
    chk(smi_st == 1'b0 && sci_st == 1'b0, "R7 status preinit", {smi_st, sci_st}, 0);
    chk(wake_n == 1'b1, "R7 wake preinit", wake_n, 1);
    chk(smi_cnt + sci_cnt == 0, "R7 pulses preinit", smi_cnt + sci_cnt, 0);
  endtask

  task automatic t_smi_edge();
    clear_mon();
    do_update(8'h01);
    chk(smi_st == 1'b1, "R2 smi status set", smi_st, 1);
    idle(60);
    chk(smi_cnt == 1, "R2 smi first pulse", smi_cnt, 1);
    chk(smi_w == LOW_W, "R1 smi low width", smi_w, LOW_W);
    do_update(8'h01);
    idle(60);
    chk(smi_cnt == 1, "R2 no repeat smi", smi_cnt, 1);
    do_update(8'h00);
    chk(smi_st == 1'b0, "R3 smi status clear", smi_st, 0);
    do_update(8'h01);
    idle(60);
    chk(smi_cnt == 2, "R3 smi re-arm", smi_cnt, 2);
    do_update(8'h00);
  endtask

  task automatic t_sci_each();
    clear_mon();
    do_update(8'h02);
    chk(sci_st == 1'b1, "R4 sci status set", sci_st, 1);
    idle(60);
    do_update(8'h02);
    idle(60);
    chk(sci_cnt == 2, "R4 sci per update", sci_cnt, 2);
    chk(sci_w == LOW_W, "R1 sci low width", sci_w, LOW_W);
    do_update(8'h00);
    chk(sci_st == 1'b0, "R4 sci status clear", sci_st, 0);
    idle(60);
    chk(sci_cnt == 2, "R4 no sci when empty", sci_cnt, 2);
  endtask

  task automatic t_wake();
    do_update(8'h04);
    chk(wake_n == 1'b1, "R6 power button ignored", wake_n, 1);
    do_update(8'h08);
    chk(wake_n == 1'b0, "R5 wake asserted", wake_n, 0);
    do_update(8'h0C);
    chk(wake_n == 1'b0, "R5 wake with pwr too", wake_n, 0);
    do_update(8'h00);
    chk(wake_n == 1'b1, "R5 wake released", wake_n, 1);
    idle(10);
  endtask

  task automatic t_acpi();
    clear_mon();
    do_acpi();
    idle(60);
    chk(sci_cnt == 1, "R8 mailbox write sci", sci_cnt, 1);
    chk(smi_cnt == 0, "R8 no smi on write", smi_cnt, 0);
  endtask

  task automatic t_queue();
    clear_mon();
    do_update(8'h02);
    idle(2);
    do_update(8'h02);
    idle(2);
    do_update(8'h02);
    idle(120);
    chk(sci_cnt == 2, "R9 coalesced sci", sci_cnt, 2);
    do_update(8'h00);
    idle(10);
  endtask

  task automatic t_prio();
    clear_mon();
    do_update(8'h03);
    idle(120);
    chk(smi_cnt == 1 && sci_cnt == 1, "R10 both pulsed", smi_cnt * 10 + sci_cnt, 11);
    chk(log_idx >= 2 && order_log[0] == 1 && order_log[1] == 2, "R10 smi first",
        order_log[0] * 10 + order_log[1], 12);
    do_update(8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    order_log = '{default: 0};
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_preinit();
    @(negedge clk); init_done = 1'b1;
    t_smi_edge();
    t_sci_each();
    t_wake();
    t_acpi();
    t_queue();
    t_prio();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule